// File: doc/BRIEF.md
# Serial Audio Link Power Sequencer

This block is the controller-side sequencer that takes a serial audio codec link down into low power and brings it back. When software issues the write that powers the codec down, the sequencer first tells the frame formatter to leave the slot data of that frame empty. At the strobe that marks the point in the frame where the codec is taken to stop its bit clock, it forces the frame-sync and serial-data outputs low and starts a quiet period.

The quiet period lasts a parameterised number of frame periods and is timed from the free-running system clock, since no bit clock exists then. A wake request that arrives during the quiet period is held and carried out when the period ends. A request that arrives later is carried out at once. The wake itself is an asynchronous high pulse on the sync line of fixed minimum length, also timed from the system clock. The sequencer then synchronises the returning bit clock into the system domain and counts its rising edges. It reports the link ready once a set number of edges has been seen.

While the link is up, the formatter's sync and data pass straight through.

Top module: `link_pwr_seq`

## Requirements
- R1: During and after reset the sequencer waits for the bit clock: link_ready, link_down, slot_data_mute, sync_out and sdo_out are all 0.
- R2: While the link is ready, sync_out equals frm_sync_in and sdo_out equals frm_sdo_in in the same cycle.
- R3: After a pd_write pulse is sampled, slot_data_mute is 1 from the next cycle until pd_slot_mark is sampled, and link_ready stays 1 meanwhile.
- R4: From the cycle after pd_slot_mark is sampled, link_down is 1, link_ready is 0, and sdo_out is 0 whatever frm_sdo_in is. sdo_out is 0 whenever link_ready is 0.
- R5: After link_down rises, sync_out stays 0 for at least HOLD_CYC = ceil(HOLD_FRAMES*FRAME_NS/CLK_PERIOD_NS) system cycles (4167 at the defaults).
- R6: A wake_req sampled k cycles after the slot mark, with 1 <= k <= HOLD_CYC, is latched and sync_out rises exactly HOLD_CYC cycles after link_down rose.
- R7: A wake_req sampled k > HOLD_CYC cycles after the slot mark makes sync_out rise exactly k cycles after link_down rose.
- R8: The wake pulse holds sync_out at 1 for exactly PULSE_CYC = ceil(PULSE_NS/CLK_PERIOD_NS) cycles (50 at the defaults), after which sync_out is 0 and link_down is 0.
- R9: wake_req has no effect while the link is ready: sync_out keeps following frm_sync_in and link_down stays 0.
- R10: After a wake pulse or reset, link_ready rises only after READY_EDGES (8 by default) rising bit-clock edges have been seen. With the bit clock stopped, it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Codec bit clock, asynchronous to clk, may stop |
| frm_sync_in | input | 1 | Frame sync from the formatter |
| frm_sdo_in | input | 1 | Serial data out from the formatter |
| pd_write | input | 1 | One-cycle pulse: power-down write issued to the codec |
| pd_slot_mark | input | 1 | One-cycle pulse: clock-stop point of the power-down frame |
| wake_req | input | 1 | One-cycle pulse: request a warm reset |
| sync_out | output | 1 | Frame sync towards the codec |
| sdo_out | output | 1 | Serial data towards the codec |
| slot_data_mute | output | 1 | Tells the formatter to send no slot data this frame |
| link_ready | output | 1 | Link active with a running bit clock |
| link_down | output | 1 | Quiet period or wake pulse in progress |

## Verification
The bench places the wake request on both sides of the hold-off boundary: one cycle before it, exactly on it, one cycle after it, well inside it and well past it. A design that dropped an early request would never wake. One that served it at once would pulse too soon. An off-by-one counter would shift the rising edge by a cycle. The pulse length is measured to the cycle. The ready detector gets exactly one edge fewer than it needs and must stay low, which exposes a counter that finishes early. Wake requests sent while the link runs must not disturb sync.

// File: rtl/sls_pkg.sv
package sls_pkg;
    typedef enum logic [2:0] {
        LS_WAITCLK = 3'd0,
        LS_RUN     = 3'd1,
        LS_DRAIN   = 3'd2,
        LS_QUIET   = 3'd3,
        LS_WAKE    = 3'd4
    } lstate_e;
endpackage

// File: rtl/sls_sync_chain.sv
module sls_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg_d, stg_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign stg_d[i] = d;
            end else begin : g_rest
                assign stg_d[i] = stg_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sls_edge_count.sv
module sls_edge_count #(
    parameter int SYNC_STAGES = 2,
    parameter int TARGET      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_raw,
    input  logic clear,
    output logic reached
);
    localparam int CW = $clog2(TARGET + 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } ec_t;

    ec_t  r_d, r_q;
    logic bclk_s;

    sls_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bclk_raw),
        .q     (bclk_s)
    );

    always_comb begin
        r_d      = r_q;
        r_d.prev = bclk_s;
        if (clear) begin
            r_d.cnt = '0;
        end else if (bclk_s && !r_q.prev && (r_q.cnt != CW'(TARGET))) begin
            r_d.cnt = r_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign reached = (r_q.cnt == CW'(TARGET));
endmodule

// File: rtl/link_pwr_seq.sv
module link_pwr_seq #(
    parameter int CLK_PERIOD_NS = 20,
    parameter int FRAME_NS      = 20833,
    parameter int HOLD_FRAMES   = 4,
    parameter int PULSE_NS      = 1000,
    parameter int READY_EDGES   = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic frm_sync_in,
    input  logic frm_sdo_in,
    input  logic pd_write,
    input  logic pd_slot_mark,
    input  logic wake_req,
    output logic sync_out,
    output logic sdo_out,
    output logic slot_data_mute,
    output logic link_ready,
    output logic link_down
);
    import sls_pkg::*;

    localparam int HOLD_CYC  = (HOLD_FRAMES * FRAME_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int PULSE_CYC = (PULSE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int MAX_CYC   = (HOLD_CYC > PULSE_CYC) ? HOLD_CYC : PULSE_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    typedef struct packed {
        lstate_e          state;
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } seq_t;

    seq_t r_d, r_q;
    logic clk_seen;

    sls_edge_count #(
        .SYNC_STAGES (SYNC_STAGES),
        .TARGET      (READY_EDGES)
    ) u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_raw (bclk),
        .clear    (r_q.state != LS_WAITCLK),
        .reached  (clk_seen)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            LS_WAITCLK: begin
                if (clk_seen) r_d.state = LS_RUN;
            end
            LS_RUN: begin
                if (pd_write) r_d.state = LS_DRAIN;
            end
            LS_DRAIN: begin
                if (pd_slot_mark) begin
                    r_d.state = LS_QUIET;
                    r_d.cnt   = CNT_W'(HOLD_CYC - 1);
                    r_d.pend  = 1'b0;
                end
            end
            LS_QUIET: begin
                r_d.pend = r_q.pend | wake_req;
                if (r_q.cnt == '0) begin
                    if (r_q.pend || wake_req) begin
                        r_d.state = LS_WAKE;
                        r_d.cnt   = CNT_W'(PULSE_CYC - 1);
                        r_d.pend  = 1'b0;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            LS_WAKE: begin
                if (r_q.cnt == '0) r_d.state = LS_WAITCLK;
                else               r_d.cnt   = r_q.cnt - CNT_W'(1);
            end
            default: r_d.state = LS_WAITCLK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= LS_WAITCLK;
            r_q.cnt   <= '0;
            r_q.pend  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        link_ready     = (r_q.state == LS_RUN) || (r_q.state == LS_DRAIN);
        link_down      = (r_q.state == LS_QUIET) || (r_q.state == LS_WAKE);
        slot_data_mute = (r_q.state == LS_DRAIN);
        sync_out       = link_ready ? frm_sync_in : (r_q.state == LS_WAKE);
        sdo_out        = link_ready & frm_sdo_in;
    end
endmodule

// File: rtl/link_pwr_seq_chk.sv
module link_pwr_seq_chk #(
    parameter int HOLD_CYC  = 4167,
    parameter int PULSE_CYC = 50
) (
    input logic clk,
    input logic rst_n,
    input logic sync_out,
    input logic sdo_out,
    input logic link_ready,
    input logic link_down,
    input logic slot_data_mute
);
    int lo_cnt_q, hi_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !link_down) begin
            lo_cnt_q <= 0;
            hi_cnt_q <= 0;
        end else begin
            if (!sync_out && lo_cnt_q < HOLD_CYC + 1) lo_cnt_q <= lo_cnt_q + 1;
            if (sync_out && hi_cnt_q < PULSE_CYC + 1) hi_cnt_q <= hi_cnt_q + 1;
        end
    end

    // R4: no serial data leaves while the link is not ready
    a_r4_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !link_ready |-> !sdo_out);

    // R4: down and ready are exclusive
    a_r4_down_excl: assert property (@(posedge clk) disable iff (!rst_n)
        link_down |-> !link_ready);

    // R5: sync held low for the whole hold-off
    a_r5_holdoff_low: assert property (@(posedge clk) disable iff (!rst_n)
        (link_down && lo_cnt_q < HOLD_CYC) |-> !sync_out);

    // R8: wake pulse never longer than its length
    a_r8_pulse_max: assert property (@(posedge clk) disable iff (!rst_n)
        (link_down && sync_out) |-> hi_cnt_q < PULSE_CYC);

    // R8: pulse had full length when the down phase ends
    a_r8_pulse_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_down) |-> (hi_cnt_q == PULSE_CYC) && !sync_out);

    // R3: mute only while link still active
    a_r3_mute_ready: assert property (@(posedge clk) disable iff (!rst_n)
        slot_data_mute |-> link_ready);

    // R10: ready never follows the down phase directly
    a_r10_no_direct: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_down) |-> !link_ready);
endmodule

bind link_pwr_seq link_pwr_seq_chk #(
    .HOLD_CYC  (HOLD_CYC),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sync_out       (sync_out),
    .sdo_out        (sdo_out),
    .link_ready     (link_ready),
    .link_down      (link_down),
    .slot_data_mute (slot_data_mute)
);

// File: tb/link_pwr_seq_test.sv
module link_pwr_seq_test;
    localparam int HOLD  = (4 * 20833 + 19) / 20;
    localparam int PULSE = (1000 + 19) / 20;
    localparam int EDGES = 8;
    localparam int NV    = 6;
    localparam int WAKE_K [NV] = '{1, 100, HOLD - 1, HOLD, HOLD + 1, HOLD + 300};
    localparam int EXP_L  [NV] = '{HOLD, HOLD, HOLD, HOLD, HOLD + 1, HOLD + 300};

    logic clk = 0, rst_n = 0;
    logic bclk_gen = 0, bclk_man = 0, bclk_run = 0;
    logic frm_sync_in = 0, frm_sdo_in = 0, pd_write = 0, pd_slot_mark = 0, wake_req = 0;
    logic sync_out, sdo_out, slot_data_mute, link_ready, link_down;
    wire  bclk = bclk_run ? bclk_gen : bclk_man;
    int   n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;
    always #40 bclk_gen = ~bclk_gen;

    link_pwr_seq uut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk),
        .frm_sync_in(frm_sync_in), .frm_sdo_in(frm_sdo_in),
        .pd_write(pd_write), .pd_slot_mark(pd_slot_mark), .wake_req(wake_req),
        .sync_out(sync_out), .sdo_out(sdo_out), .slot_data_mute(slot_data_mute),
        .link_ready(link_ready), .link_down(link_down)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic man_pulse();
        bclk_man = 1; cyc(5); bclk_man = 0; cyc(5);
    endtask

    task automatic run_main();
        int l, w;
        bit sdo_bad;
        // R1: reset state
        cyc(3);
        chk(!link_ready && !link_down && !slot_data_mute && !sync_out && !sdo_out,
            "R1 reset outputs", {link_ready, link_down, slot_data_mute, sync_out, sdo_out}, 0);
        rst_n = 1;
        frm_sync_in = 1; frm_sdo_in = 1;
        cyc(50);
        chk(!link_ready && !sdo_out, "R10 no bclk stays not ready", link_ready, 0);
        for (int i = 0; i < EDGES - 1; i++) man_pulse();
        cyc(10);
        chk(!link_ready, "R10 one edge short", link_ready, 0);
        man_pulse();
        cyc(10);
        chk(link_ready, "R10 ready after full edge count", link_ready, 1);
        bclk_run = 1;

        for (int v = 0; v < NV; v++) begin
            frm_sync_in = 1; frm_sdo_in = 1;
            @(negedge clk);
            chk(sync_out && sdo_out && link_ready, "R2 passthrough high", {sync_out, sdo_out}, 3);
            frm_sync_in = 0; frm_sdo_in = 0; wake_req = 1;
            @(negedge clk);
            wake_req = 0;
            chk(!sync_out && !sdo_out, "R2 passthrough low", {sync_out, sdo_out}, 0);
            cyc(20);
            chk(!link_down && !sync_out && link_ready, "R9 wake ignored while running",
                {link_down, sync_out}, 0);
            frm_sync_in = 1; frm_sdo_in = 1; pd_write = 1;
            @(negedge clk);
            pd_write = 0;
            chk(slot_data_mute && link_ready && sync_out, "R3 mute after power-down write",
                slot_data_mute, 1);
            cyc(3);
            pd_slot_mark = 1;
            @(negedge clk);
            pd_slot_mark = 0;
            bclk_run = 0;
            chk(link_down && !link_ready && !sync_out && !sdo_out && !slot_data_mute,
                "R4 quiet on slot mark", {link_down, link_ready, sync_out, sdo_out}, 8);
            l = -1; sdo_bad = 0;
            for (int j = 0; j < HOLD + 1000; j++) begin
                if (sync_out) begin l = j; break; end
                if (sdo_out || link_ready) sdo_bad = 1;
                wake_req = (j == WAKE_K[v] - 1);
                @(negedge clk);
            end
            wake_req = 0;
            chk(!sdo_bad, "R4 outputs held low in quiet", sdo_bad, 0);
            chk(l == EXP_L[v], (WAKE_K[v] <= HOLD) ? "R6 latched wake start / R5 hold-off"
                                                    : "R7 late wake start", l, EXP_L[v]);
            w = 0;
            while (sync_out && w < PULSE + 20) begin w++; @(negedge clk); end
            chk(w == PULSE && !link_down && !link_ready, "R8 pulse width", w, PULSE);
            bclk_run = 1;
            w = 0;
            while (!link_ready && w < 500) begin w++; @(negedge clk); end
            chk(link_ready && w >= EDGES * 4 - 4, "R10 ready after bclk returns", w, EDGES * 4);
            chk(sync_out == frm_sync_in, "R2 passthrough after wake", sync_out, frm_sync_in);
        end
    endtask

    initial begin
        fork
            run_main();
            begin
                cyc(190000);
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule